// File: doc/BRIEF.md
# Reference-Gated Frequency Ratio Counter

The block measures how many cycles of a fast input clock fit into one period of a slower reference clock. That integer is the input-to-reference frequency ratio. Downstream it serves as the divider setting of a synthesizer loop. Counting runs on the input clock. A toggle, driven from the reference domain, ends each window. At the end of a window the count is closed, the counter clears, and the next window starts at once. The counter never runs on to rollover.

Each closed result crosses into the reference clock domain over a toggle handshake. There it appears as a 5-bit binary ratio and as a two-digit BCD copy, together with an overflow flag, a sticky valid flag and a one-cycle update strobe. While one result is still crossing, further window results are measured but not handed over.

An optional divide-by-8 mode applies to both clocks. The input side then counts only every eighth input cycle, and the window stretches to eight reference periods, so the counting logic runs at one eighth of the rate with the same result. With asynchronous clocks the ratio carries a ±1 count uncertainty.

Top module: `freq_ratio_meter`

## Requirements
- R1: With `prescale_en` low, the reported ratio equals the number of `clk_in` rising edges in one `clk_ref` period. For clocks locked at an integer ratio N this is exactly N; for unrelated clocks it is within ±1.
- R2: The ratio is an unsigned binary value of 5 bits, so every ratio from 1 to 31 is reported exactly, including 31.
- R3: A window holding more than 31 counts reports a ratio of 31 with `ratio_ovf` high. A window of 31 counts or fewer reports `ratio_ovf` low.
- R4: `ratio_bcd[3:0]` holds the units digit and `ratio_bcd[5:4]` the tens digit of `ratio`. Each digit is in plain binary.
- R5: With `prescale_en` high, the window lasts eight `clk_ref` periods and only every eighth `clk_in` cycle is counted, so the reported ratio is the same N as in R1.
- R6: `ratio_strobe` is high for exactly one `clk_ref` cycle, in the same cycle that a newly handed-over result appears. `ratio`, `ratio_bcd` and `ratio_ovf` change in no other cycle, and the handover register on the input side changes only when a new result is loaded.
- R7: While reset is low, and after reset until the first strobe, `ratio`, `ratio_bcd` and `ratio_ovf` are zero and `ratio_valid` is low. The partial window that follows reset is never reported. Once `ratio_valid` rises it stays high until the next reset.
- R8: Measurement restarts on its own after every window. With steady clocks, successive strobes report the same value, with no drift or rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock being measured; drives the counting logic |
| clk_ref | input | 1 | Reference clock; sets the window and clocks the result outputs |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| prescale_en | input | 1 | Divide-by-8 mode for both clocks (quasi-static) |
| ratio | output | 5 | Latched ratio, saturated at 31 |
| ratio_bcd | output | 6 | Two-digit BCD copy of `ratio`: tens in [5:4], units in [3:0] |
| ratio_ovf | output | 1 | The latched window exceeded the 5-bit range |
| ratio_valid | output | 1 | At least one result has been handed over since reset |
| ratio_strobe | output | 1 | One `clk_ref` cycle pulse marking a new result |

## Verification
A result is due one strobe after its window closes. The delay is two synchronizer stages plus one capture register in the `clk_ref` domain. The acknowledge then takes two `clk_in` stages to return, so several windows may pass between strobes. For that reason the bench never predicts a strobe cycle. It waits for each strobe and samples all outputs at the falling `clk_ref` edge of that cycle. After any change of ratio or mode it discards the first three strobes, because those may carry a pending old result or a window that straddles the change. It compares the next two strobes with values computed from the reference period it generates.

// File: rtl/frc_pkg.sv
package frc_pkg;

  localparam int DEF_RATIO_W      = 5;
  localparam int DEF_PRESCALE_LOG = 3;
  localparam int DEF_SYNC_STAGES  = 2;

  // Digit width for the tens place of the largest value of a w-bit count.
  function automatic int tens_width(input int w);
    int top;
    top = ((1 << w) - 1) / 10;
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

  // Two-digit BCD packing: tens above bit 4, units in the low nibble.
  function automatic int bcd_pack(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

endpackage

// File: rtl/frc_sync.sv
module frc_sync #(
  parameter int STAGES = frc_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/frc_ref_pacer.sv
module frc_ref_pacer #(
  parameter int PRESCALE_LOG = frc_pkg::DEF_PRESCALE_LOG
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic prescale_en,
  output logic ref_tgl
);

  logic [PRESCALE_LOG-1:0] pre_cnt;
  logic                    flip;

  assign flip = !prescale_en || (pre_cnt == '1);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      ref_tgl <= 1'b0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      if (flip) ref_tgl <= ~ref_tgl;
    end
  end

endmodule

// File: rtl/frc_window_counter.sv
module frc_window_counter #(
  parameter int RATIO_W      = frc_pkg::DEF_RATIO_W,
  parameter int PRESCALE_LOG = frc_pkg::DEF_PRESCALE_LOG,
  parameter int SYNC_STAGES  = frc_pkg::DEF_SYNC_STAGES
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               prescale_en,
  input  logic               ref_tgl,
  input  logic               ack_tgl,
  output logic               req_tgl,
  output logic [RATIO_W-1:0] hold_ratio,
  output logic               hold_ovf,
  output logic               result_load
);

  localparam logic [RATIO_W-1:0] CNT_MAX = '1;

  typedef struct packed {
    logic               ovf;
    logic [RATIO_W-1:0] val;
  } closed_t;

  // Final value of a window: this cycle's tick is part of the window.
  function automatic closed_t close_window(input logic [RATIO_W-1:0] c,
                                           input logic sat,
                                           input logic t);
    closed_t r;
    if (sat || (c == CNT_MAX && t)) begin
      r.ovf = 1'b1;
      r.val = CNT_MAX;
    end else begin
      r.ovf = 1'b0;
      r.val = c + RATIO_W'(t);
    end
    return r;
  endfunction

  logic                    ref_s, ref_d;
  logic                    ack_s;
  logic                    win_end;
  logic                    tick;
  logic                    armed;
  logic                    idle;
  logic                    sat;
  logic [RATIO_W-1:0]      cnt;
  logic [PRESCALE_LOG-1:0] pre_cnt;
  closed_t                 closed;

  frc_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk_in), .rst_n(rst_n), .d(ref_tgl), .q(ref_s)
  );

  frc_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk_in), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  assign win_end     = ref_s ^ ref_d;
  assign tick        = !prescale_en || (pre_cnt == '1);
  assign idle        = (ack_s == req_tgl);
  assign closed      = close_window(cnt, sat, tick);
  assign result_load = win_end && armed && idle;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      ref_d   <= 1'b0;
      pre_cnt <= '0;
      cnt     <= '0;
      sat     <= 1'b0;
      armed   <= 1'b0;
    end else begin
      ref_d   <= ref_s;
      pre_cnt <= pre_cnt + 1'b1;
      if (win_end) begin
        cnt   <= '0;
        sat   <= 1'b0;
        armed <= 1'b1;
      end else if (tick) begin
        if (cnt == CNT_MAX) sat <= 1'b1;
        else                cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl    <= 1'b0;
      hold_ratio <= '0;
      hold_ovf   <= 1'b0;
    end else if (result_load) begin
      req_tgl    <= ~req_tgl;
      hold_ratio <= closed.val;
      hold_ovf   <= closed.ovf;
    end
  end

endmodule

// File: rtl/frc_result_port.sv
module frc_result_port #(
  parameter int RATIO_W     = frc_pkg::DEF_RATIO_W,
  parameter int BCD_W       = 4 + frc_pkg::tens_width(frc_pkg::DEF_RATIO_W),
  parameter int SYNC_STAGES = frc_pkg::DEF_SYNC_STAGES
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               req_tgl,
  input  logic [RATIO_W-1:0] hold_ratio,
  input  logic               hold_ovf,
  output logic               ack_tgl,
  output logic [RATIO_W-1:0] ratio,
  output logic [BCD_W-1:0]   ratio_bcd,
  output logic               ratio_ovf,
  output logic               ratio_valid,
  output logic               ratio_strobe
);

  function automatic logic [BCD_W-1:0] to_bcd(input logic [RATIO_W-1:0] v);
    return BCD_W'(frc_pkg::bcd_pack(int'(v)));
  endfunction

  logic req_s;
  logic req_seen;
  logic capture;

  frc_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  assign capture = req_s ^ req_seen;
  assign ack_tgl = req_seen;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      req_seen     <= 1'b0;
      ratio        <= '0;
      ratio_bcd    <= '0;
      ratio_ovf    <= 1'b0;
      ratio_valid  <= 1'b0;
      ratio_strobe <= 1'b0;
    end else begin
      req_seen     <= req_s;
      ratio_strobe <= capture;
      if (capture) begin
        ratio       <= hold_ratio;
        ratio_bcd   <= to_bcd(hold_ratio);
        ratio_ovf   <= hold_ovf;
        ratio_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/freq_ratio_meter.sv
module freq_ratio_meter #(
  parameter int RATIO_W      = frc_pkg::DEF_RATIO_W,
  parameter int PRESCALE_LOG = frc_pkg::DEF_PRESCALE_LOG,
  parameter int SYNC_STAGES  = frc_pkg::DEF_SYNC_STAGES,
  localparam int BCD_W       = 4 + frc_pkg::tens_width(RATIO_W)
) (
  input  logic               clk_in,
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               prescale_en,
  output logic [RATIO_W-1:0] ratio,
  output logic [BCD_W-1:0]   ratio_bcd,
  output logic               ratio_ovf,
  output logic               ratio_valid,
  output logic               ratio_strobe
);

  logic               ref_tgl;
  logic               req_tgl;
  logic               ack_tgl;
  logic [RATIO_W-1:0] hold_ratio;
  logic               hold_ovf;
  logic               result_load;

  frc_ref_pacer #(.PRESCALE_LOG(PRESCALE_LOG)) u_pacer (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .prescale_en (prescale_en),
    .ref_tgl     (ref_tgl)
  );

  frc_window_counter #(
    .RATIO_W(RATIO_W), .PRESCALE_LOG(PRESCALE_LOG), .SYNC_STAGES(SYNC_STAGES)
  ) u_counter (
    .clk_in      (clk_in),
    .rst_n       (rst_n),
    .prescale_en (prescale_en),
    .ref_tgl     (ref_tgl),
    .ack_tgl     (ack_tgl),
    .req_tgl     (req_tgl),
    .hold_ratio  (hold_ratio),
    .hold_ovf    (hold_ovf),
    .result_load (result_load)
  );

  frc_result_port #(
    .RATIO_W(RATIO_W), .BCD_W(BCD_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_port (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .req_tgl      (req_tgl),
    .hold_ratio   (hold_ratio),
    .hold_ovf     (hold_ovf),
    .ack_tgl      (ack_tgl),
    .ratio        (ratio),
    .ratio_bcd    (ratio_bcd),
    .ratio_ovf    (ratio_ovf),
    .ratio_valid  (ratio_valid),
    .ratio_strobe (ratio_strobe)
  );

endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int RATIO_W = 5,
  parameter int BCD_W   = 6
) (
  input logic               clk_in,
  input logic               clk_ref,
  input logic               rst_n,
  input logic [RATIO_W-1:0] ratio,
  input logic [BCD_W-1:0]   ratio_bcd,
  input logic               ratio_ovf,
  input logic               ratio_valid,
  input logic               ratio_strobe,
  input logic [RATIO_W-1:0] hold_ratio,
  input logic               hold_ovf,
  input logic               result_load
);

  localparam logic [RATIO_W-1:0] TOP = '1;

  a_r6_strobe_single: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ratio_strobe |=> !ratio_strobe);

  a_r6_outputs_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !ratio_strobe |-> ($stable(ratio) && $stable(ratio_bcd) && $stable(ratio_ovf)));

  a_r6_strobe_valid: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ratio_strobe |-> ratio_valid);

  a_r7_valid_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ratio_valid |=> ratio_valid);

  a_r7_idle_zero: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !ratio_valid |-> (ratio == '0 && ratio_bcd == '0 && !ratio_ovf));

  a_r3_ovf_at_max: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ratio_ovf |-> (ratio == TOP));

  a_r4_bcd_digits: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ratio_bcd[3:0] < 4'd10) &&
    (int'(ratio_bcd[BCD_W-1:4]) * 10 + int'(ratio_bcd[3:0]) == int'(ratio)));

  a_r6_hold_steady: assert property (@(posedge clk_in) disable iff (!rst_n)
    !result_load |=> ($stable(hold_ratio) && $stable(hold_ovf)));

endmodule

bind freq_ratio_meter frc_checker #(.RATIO_W(RATIO_W), .BCD_W(BCD_W)) u_chk (
  .clk_in       (clk_in),
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .ratio        (ratio),
  .ratio_bcd    (ratio_bcd),
  .ratio_ovf    (ratio_ovf),
  .ratio_valid  (ratio_valid),
  .ratio_strobe (ratio_strobe),
  .hold_ratio   (hold_ratio),
  .hold_ovf     (hold_ovf),
  .result_load  (result_load)
);

// File: tb/freq_ratio_meter_tb.sv
module freq_ratio_meter_tb;

  localparam int MAXV = 31;

  logic clk_in = 1'b0;
  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic prescale_en = 1'b0;
  logic [4:0] ratio;
  logic [5:0] ratio_bcd;
  logic ratio_ovf, ratio_valid, ratio_strobe;

  int cur_n = 10;
  int ref_ph = 0;
  int n_cmp = 0;
  int n_bad = 0;
  int nstrobe = 0;
  int s_ratio, s_bcd, s_ovf, s_valid;
  bit seen_first = 0;
  bit pre_bad = 0;
  bit r6_bad = 0;
  bit prev_strobe = 0;
  int prev_ratio = 0;
  bit done = 0;

  always #4 clk_in = ~clk_in;

  // Reference clock locked to clk_in at ratio cur_n, edges 1 ns after clk_in.
  initial forever begin
    @(posedge clk_in);
    #1;
    ref_ph = (ref_ph + 1 >= cur_n) ? 0 : ref_ph + 1;
    clk_ref = (ref_ph == 0) || (ref_ph < cur_n / 2);
  end

  freq_ratio_meter u_dut (
    .clk_in(clk_in), .clk_ref(clk_ref), .rst_n(rst_n), .prescale_en(prescale_en),
    .ratio(ratio), .ratio_bcd(ratio_bcd), .ratio_ovf(ratio_ovf),
    .ratio_valid(ratio_valid), .ratio_strobe(ratio_strobe)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_ref) begin
    if (!rst_n) begin
      seen_first = 0;
      prev_strobe = 0;
      prev_ratio = 0;
    end else begin
      if (!seen_first && !ratio_strobe &&
          (ratio_valid || ratio != 0 || ratio_bcd != 0 || ratio_ovf)) pre_bad = 1;
      if (ratio_strobe && prev_strobe) r6_bad = 1;
      if (!ratio_strobe && int'(ratio) != prev_ratio) r6_bad = 1;
      if (ratio_strobe) begin
        seen_first = 1;
        nstrobe++;
        s_ratio = int'(ratio);
        s_bcd = int'(ratio_bcd);
        s_ovf = int'(ratio_ovf);
        s_valid = int'(ratio_valid);
      end
      prev_strobe = ratio_strobe;
      prev_ratio = int'(ratio);
    end
  end

  task automatic wait_strobe();
    int start = nstrobe;
    int guard = 0;
    while (nstrobe == start && guard < 20000) begin
      @(negedge clk_in);
      guard++;
    end
    if (nstrobe == start) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8: actual no strobe expected a strobe (n=%0d)", cur_n);
    end
  endtask

  // BCD by repeated subtraction, tens in [5:4], units in [3:0].
  function automatic int bench_bcd(input int v);
    int t = 0;
    int u = v;
    while (u >= 10) begin
      u -= 10;
      t++;
    end
    return t * 16 + u;
  endfunction

  task automatic run_case(input int n, input bit pre);
    int e_ratio = (n > MAXV) ? MAXV : n;
    int e_ovf = (n > MAXV) ? 1 : 0;
    string tag;
    cur_n = n;
    prescale_en = pre;
    repeat (3) wait_strobe();
    for (int k = 0; k < 2; k++) begin
      wait_strobe();
      if (k == 1) tag = "R8";
      else if (pre) tag = "R5";
      else if (n > MAXV) tag = "R3";
      else if (n == MAXV) tag = "R2";
      else tag = "R1";
      check($sformatf("%s ratio n=%0d pre=%0d", tag, n, pre), s_ratio, e_ratio);
      check($sformatf("R3 ovf n=%0d", n), s_ovf, e_ovf);
      check($sformatf("R4 bcd n=%0d", n), s_bcd, bench_bcd(e_ratio));
      check($sformatf("R7 valid n=%0d", n), s_valid, 1);
    end
  endtask

  task automatic check_reset_state(input string why);
    check({"R7 reset ratio ", why}, int'(ratio), 0);
    check({"R7 reset bcd ", why}, int'(ratio_bcd), 0);
    check({"R7 reset ovf ", why}, int'(ratio_ovf), 0);
    check({"R7 reset valid ", why}, int'(ratio_valid), 0);
    check({"R7 reset strobe ", why}, int'(ratio_strobe), 0);
  endtask

  initial begin
    repeat (60) @(negedge clk_in);
    check_reset_state("power-up");
    rst_n = 1'b1;
    for (int n = 3; n <= 40; n++) run_case(n, 1'b0);
    run_case(4, 1'b1);
    run_case(12, 1'b1);
    run_case(20, 1'b1);
    run_case(31, 1'b1);
    run_case(33, 1'b1);
    cur_n = 15;
    prescale_en = 1'b0;
    repeat (100) @(negedge clk_in);
    rst_n = 1'b0;
    repeat (40) @(negedge clk_in);
    check_reset_state("mid-run");
    rst_n = 1'b1;
    run_case(15, 1'b0);
    check("R6 strobe width and output stability", int'(r6_bad), 0);
    check("R7 outputs idle before first strobe", int'(pre_bad), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_in);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule